// File: doc/BRIEF.md
# Boot ROM and Display Bus Decoder

This block decodes the control side of a small 8-bit computer bus. It decides, from the memory read and write strobes and the low address bits, whether a 32-byte monitor ROM or the RAM answers the current cycle. It gates the write strobe with a memory-protect flag and drives the bus enable that places keypad data on the data bus. It also owns a two-digit display register that latches the data bus.

The ROM overlays reads of locations 0 to 31 only while the monitor is selected. Writes to those locations always reach RAM, so the ROM never drives the bus against a write. In normal operation the display register behaves as an output port and loads only on an output instruction. This is the TPB pulse with the read strobe and the N2 I/O select both high. While single-step is selected, a small mode machine moves the display into a trace state in which it copies the data bus on every clock.

The mode machine has two states. DM_PORT is the reset state, in which the display loads only on the port strobe. DM_TRACE is the state in which the display follows the bus. Transition ENTER_TRACE goes from DM_PORT to DM_TRACE when `sstep` is high at a clock edge. Transition LEAVE_TRACE goes from DM_TRACE to DM_PORT when `sstep` is low at a clock edge.

Top module: `bus_decoder`

## Requirements
- R1: `rom_en` is 1 exactly when `mem_rd` is 1, `mon_sel` is 1 and address bits 7, 6 and 5 are all 0. A write never enables the ROM.
- R2: `ram_en` is 1 when `mem_rd` or `mem_wr_in` is 1, `rom_en` is 0 and `ram_off` is 0. Otherwise it is 0.
- R3: A write to any address from 0 to 31 with `mon_sel` set gives `ram_en`=1 and `rom_en`=0.
- R4: While `wr_protect` is 1, `mem_wr` is 0. While it is 0, `mem_wr` equals `mem_wr_in`.
- R5: In DM_PORT, `disp_ld` is 1 exactly when `tpb`, `mem_rd` and `io_n2` are all 1. At the clock edge where `disp_ld` is 1, `disp` takes the value of `dbus`.
- R6: Between loads `disp` holds its value.
- R7: After `sstep` rises, the mode is DM_TRACE from the next clock edge onward. From then on `disp_ld` is 1 and `disp` copies `dbus` at every edge. One edge after `sstep` falls, the mode is back in DM_PORT and `disp` holds again.
- R8: `kb_en` is 1 when `load_mode` is 1, or when `io_n2` and `mem_rd` are both 1.
- R9: `ram_off`=1 forces `ram_en` to 0 whatever the other inputs are.
- R10: After reset, `disp` is 8'h00 and the mode is DM_PORT, so `disp_ld` is 0 with no port strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 8 | Low address bits |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr_in | input | 1 | Memory write strobe from CPU, active high |
| tpb | input | 1 | TPB timing pulse |
| io_n2 | input | 1 | N2 I/O select line |
| load_mode | input | 1 | Load mode flag |
| mon_sel | input | 1 | Monitor ROM selected |
| wr_protect | input | 1 | Memory protect flag |
| sstep | input | 1 | Single-step selected |
| ram_off | input | 1 | Active-high RAM disable |
| dbus | input | 8 | Data bus value |
| rom_en | output | 1 | Monitor ROM enable |
| ram_en | output | 1 | RAM enable |
| mem_wr | output | 1 | Gated memory write |
| disp_ld | output | 1 | Display register load enable |
| kb_en | output | 1 | Keypad-to-bus enable |
| disp | output | 8 | Display register contents |

## Verification
The keypad bus enable and the display load can fire in the same cycle, because an I/O cycle with N2 and the read strobe both high satisfies both. The bench provokes this by raising `tpb`, `mem_rd` and `io_n2` together. It checks that `kb_en` and `disp_ld` are both high in that cycle, and that the display takes the bus value at the following edge. A port strobe issued while already in DM_TRACE is also checked: the bus value must simply be copied once, as in the trace state.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
    typedef enum logic {
        DM_PORT  = 1'b0,
        DM_TRACE = 1'b1
    } disp_mode_e;
endpackage

// File: rtl/mem_select.sv
module mem_select #(
    parameter int ADDR_W    = 8,
    parameter int ROM_DEPTH = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_rd,
    input  logic              mem_wr_in,
    input  logic              mon_sel,
    input  logic              wr_protect,
    input  logic              ram_off,
    output logic              rom_en,
    output logic              ram_en,
    output logic              mem_wr
);
    localparam int ROM_AW = $clog2(ROM_DEPTH);

    logic in_rom_window;

    // Upper address bits all zero means the access lies in the overlay window.
    assign in_rom_window = (addr[ADDR_W-1:ROM_AW] == '0);

    always_comb begin
        rom_en = mem_rd && mon_sel && in_rom_window;
        ram_en = (mem_rd || mem_wr_in) && !rom_en && !ram_off;
        mem_wr = mem_wr_in && !wr_protect;
    end
endmodule

// File: rtl/disp_latch.sv
module disp_latch
    import bus_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sstep,
    input  logic              port_ld,
    input  logic [DATA_W-1:0] dbus,
    output logic              disp_ld,
    output logic [DATA_W-1:0] disp
);
    disp_mode_e state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DM_PORT;
        else        state_q <= state_d;
    end

    // Transitions: ENTER_TRACE and LEAVE_TRACE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DM_PORT:  if (sstep)  state_d = DM_TRACE;
            DM_TRACE: if (!sstep) state_d = DM_PORT;
            default:              state_d = DM_PORT;
        endcase
    end

    // Outputs.
    always_comb begin
        disp_ld = 1'b0;
        unique case (state_q)
            DM_PORT:  disp_ld = port_ld;
            DM_TRACE: disp_ld = 1'b1;
            default:  disp_ld = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       disp <= '0;
        else if (disp_ld) disp <= dbus;
    end
endmodule

// File: rtl/bus_decoder.sv
module bus_decoder #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int ROM_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_rd,
    input  logic              mem_wr_in,
    input  logic              tpb,
    input  logic              io_n2,
    input  logic              load_mode,
    input  logic              mon_sel,
    input  logic              wr_protect,
    input  logic              sstep,
    input  logic              ram_off,
    input  logic [DATA_W-1:0] dbus,
    output logic              rom_en,
    output logic              ram_en,
    output logic              mem_wr,
    output logic              disp_ld,
    output logic              kb_en,
    output logic [DATA_W-1:0] disp
);
    logic io_rd;
    logic port_ld;

    assign io_rd   = io_n2 && mem_rd;
    assign port_ld = io_rd && tpb;
    assign kb_en   = load_mode || io_rd;

    mem_select #(
        .ADDR_W    (ADDR_W),
        .ROM_DEPTH (ROM_DEPTH)
    ) u_msel (
        .addr       (addr),
        .mem_rd     (mem_rd),
        .mem_wr_in  (mem_wr_in),
        .mon_sel    (mon_sel),
        .wr_protect (wr_protect),
        .ram_off    (ram_off),
        .rom_en     (rom_en),
        .ram_en     (ram_en),
        .mem_wr     (mem_wr)
    );

    disp_latch #(
        .DATA_W (DATA_W)
    ) u_disp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sstep   (sstep),
        .port_ld (port_ld),
        .dbus    (dbus),
        .disp_ld (disp_ld),
        .disp    (disp)
    );
endmodule

// File: rtl/bus_decoder_chk.sv
module bus_decoder_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int ROM_DEPTH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              mem_rd,
    input logic              mem_wr_in,
    input logic              mon_sel,
    input logic              wr_protect,
    input logic              ram_off,
    input logic              sstep,
    input logic [DATA_W-1:0] dbus,
    input logic              rom_en,
    input logic              ram_en,
    input logic              mem_wr,
    input logic              disp_ld,
    input logic [DATA_W-1:0] disp
);
    localparam int ROM_AW = $clog2(ROM_DEPTH);

    AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |-> (mem_rd && mon_sel && addr[ADDR_W-1:ROM_AW] == '0)); // R1
    AST_NO_DUAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_en && ram_en)); // R2
    AST_LOW_WRITE_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_in && !mem_rd && !ram_off) |-> (ram_en && !rom_en)); // R3
    AST_PROTECT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_protect |-> !mem_wr); // R4
    AST_DISP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ld |=> (disp == $past(dbus))); // R5
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_ld |=> $stable(disp)); // R6
    AST_TRACE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sstep |=> disp_ld); // R7
    AST_RAM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ram_off |-> !ram_en); // R9
endmodule

bind bus_decoder bus_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ROM_DEPTH (ROM_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .mem_rd     (mem_rd),
    .mem_wr_in  (mem_wr_in),
    .mon_sel    (mon_sel),
    .wr_protect (wr_protect),
    .ram_off    (ram_off),
    .sstep      (sstep),
    .dbus       (dbus),
    .rom_en     (rom_en),
    .ram_en     (ram_en),
    .mem_wr     (mem_wr),
    .disp_ld    (disp_ld),
    .disp       (disp)
);

// File: tb/tb_bus_decoder.sv
module tb_bus_decoder;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] addr;
    logic       mem_rd, mem_wr_in, tpb, io_n2, load_mode, mon_sel;
    logic       wr_protect, sstep, ram_off;
    logic [7:0] dbus;
    logic       rom_en, ram_en, mem_wr, disp_ld, kb_en;
    logic [7:0] disp;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bus_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_rd(mem_rd),
        .mem_wr_in(mem_wr_in), .tpb(tpb), .io_n2(io_n2),
        .load_mode(load_mode), .mon_sel(mon_sel), .wr_protect(wr_protect),
        .sstep(sstep), .ram_off(ram_off), .dbus(dbus), .rom_en(rom_en),
        .ram_en(ram_en), .mem_wr(mem_wr), .disp_ld(disp_ld), .kb_en(kb_en),
        .disp(disp)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        addr = 8'h00; mem_rd = 0; mem_wr_in = 0; tpb = 0; io_n2 = 0;
        load_mode = 0; mon_sel = 0; wr_protect = 0; sstep = 0; ram_off = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; dbus = 8'h5A;
        idle();
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #2;
        check("R10 disp after reset", disp, 8'h00);
        check("R10 disp_ld idle", {7'b0, disp_ld}, 8'h00);
    endtask

    task automatic t_rom();
        for (int a = 0; a < 256; a += 13) begin
            idle(); addr = 8'(a); mem_rd = 1; mon_sel = 1; #2;
            check("R1 rom_en on read", {7'b0, rom_en}, {7'b0, (a < 32)});
            check("R2 ram_en on read", {7'b0, ram_en}, {7'b0, (a >= 32)});
        end
        idle(); addr = 8'h10; mem_rd = 1; mon_sel = 0; #2;
        check("R1 no monitor", {7'b0, rom_en}, 8'h00);
        check("R2 ram without monitor", {7'b0, ram_en}, 8'h01);
        idle(); addr = 8'h10; #2;
        check("R2 no strobe", {7'b0, ram_en}, 8'h00);
    endtask

    task automatic t_low_write();
        idle(); addr = 8'h1F; mem_wr_in = 1; mon_sel = 1; #2;
        check("R3 rom_en on write", {7'b0, rom_en}, 8'h00);
        check("R3 ram_en on write", {7'b0, ram_en}, 8'h01);
        check("R4 write passes", {7'b0, mem_wr}, 8'h01);
    endtask

    task automatic t_protect();
        idle(); addr = 8'h40; mem_wr_in = 1; wr_protect = 1; #2;
        check("R4 protect blocks", {7'b0, mem_wr}, 8'h00);
        wr_protect = 0; #2;
        check("R4 unprotect", {7'b0, mem_wr}, 8'h01);
    endtask

    task automatic t_port();
        idle(); dbus = 8'h3C; mem_rd = 1; io_n2 = 1; #2;
        check("R5 no tpb no load", {7'b0, disp_ld}, 8'h00);
        tpb = 1; #2;
        check("R5 port strobe", {7'b0, disp_ld}, 8'h01);
        check("R8 kb_en same cycle", {7'b0, kb_en}, 8'h01);
        @(posedge clk); #2;
        check("R5 disp loaded", disp, 8'h3C);
    endtask

    task automatic t_hold();
        idle(); dbus = 8'hA7; mem_rd = 1; tpb = 1;
        @(posedge clk); #2;
        check("R6 hold without n2", disp, 8'h3C);
        idle(); dbus = 8'h11; io_n2 = 1; tpb = 1;
        @(posedge clk); #2;
        check("R6 hold without read", disp, 8'h3C);
    endtask

    task automatic t_trace();
        idle(); sstep = 1; dbus = 8'h21;
        @(posedge clk); #2;
        check("R7 mode trace", {7'b0, disp_ld}, 8'h01);
        @(posedge clk); #2;
        check("R7 follow 1", disp, 8'h21);
        @(negedge clk); dbus = 8'h9E;
        @(posedge clk); #2;
        check("R7 follow 2", disp, 8'h9E);
        @(negedge clk); dbus = 8'h44; mem_rd = 1; io_n2 = 1; tpb = 1;
        @(posedge clk); #2;
        check("R7 strobe in trace", disp, 8'h44);
        idle(); dbus = 8'h55;
        @(posedge clk); #2;
        check("R7 last trace load", disp, 8'h55);
        @(negedge clk); dbus = 8'hCD;
        @(posedge clk); #2;
        check("R7 back to port hold", disp, 8'h55);
        check("R7 disp_ld low", {7'b0, disp_ld}, 8'h00);
    endtask

    task automatic t_kb();
        idle(); load_mode = 1; #2;
        check("R8 load mode", {7'b0, kb_en}, 8'h01);
        idle(); io_n2 = 1; #2;
        check("R8 n2 only", {7'b0, kb_en}, 8'h00);
        mem_rd = 1; #2;
        check("R8 n2 and read", {7'b0, kb_en}, 8'h01);
    endtask

    task automatic t_ram_off();
        idle(); addr = 8'h80; mem_rd = 1; ram_off = 1; #2;
        check("R9 read disabled", {7'b0, ram_en}, 8'h00);
        mem_rd = 0; mem_wr_in = 1; #2;
        check("R9 write disabled", {7'b0, ram_en}, 8'h00);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rom();
        t_low_write();
        t_protect();
        t_port();
        t_hold();
        t_trace();
        t_kb();
        t_ram_off();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule